// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block is an eight-bit general-purpose I/O port for a small processor core. Each bit has no direction register. A single output latch decides the bit's behaviour. A latch bit at zero turns on an open-drain pull-down. A latch bit at one releases the pin, which then sits high through a set of pull-ups and can be driven low from outside, so the bit acts as an input. For every bit the block drives four pad controls: the pull-down, a short strong pull-up pulse that speeds a low-to-high edge, a keeper pull-up that holds a high level, and a very weak pull-up.

The CPU side has a byte write, a single-bit modify and a read. A read marked as read-modify-write returns the latch. A plain read returns the synchronised pin levels. Reading the latch avoids a false zero when a released pin is loaded by an external circuit. A bit modify reads the whole latch, replaces the addressed bit and writes the full byte back. Pins enter as digital levels and pass through a synchroniser before any logic uses them.

Top module: `qbport_top`

## Requirements
- R1: After reset every latch bit holds one. weakUpEn is 0xFF, pullDownEn is 0x00 and strongUpEn is 0x00, and a read-modify-write read returns 0xFF.
- R2: When rdRmw is 0, rdData returns padIn delayed by two clock edges through the synchroniser.
- R3: When rdRmw is 1, rdData returns the latch contents, whatever the pin levels are.
- R4: A byte write (wrEn=1) loads wrData at the clock edge, and the pad controls show the new value from the next cycle. pullDownEn equals the inverted latch and weakUpEn equals the latch, so writing one releases a bit back to input.
- R5: A bit modify (bitEn=1, wrEn=0) writes bitVal into the latch bit whose index is given by bitSel (0 to 7, bit 0 = LSB). All other bits keep their value.
- R6: When wrEn and bitEn are both asserted in the same cycle, the byte write takes effect and the bit modify is ignored.
- R7: A 0-to-1 change of a latch bit asserts that bit's strongUpEn for exactly two clock cycles, starting in the cycle after the write.
- R8: A write that leaves a bit at one neither restarts nor creates a strong pulse. A 1-to-0 write ends any pulse still running on that bit.
- R9: keeperEn for a bit is one only when the synchronised pin level is one and the latch bit is one.
- R10: On any bit, pullDownEn is never asserted together with strongUpEn, keeperEn or weakUpEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte write data |
| bitEn | input | 1 | Single-bit modify strobe |
| bitSel | input | 3 | Index of the bit to modify |
| bitVal | input | 1 | Value for the modified bit |
| rdRmw | input | 1 | 1: read the latch, 0: read the pins |
| rdData | output | 8 | Read data |
| padIn | input | 8 | Pin levels from the pads |
| pullDownEn | output | 8 | Per-bit pull-down enable |
| strongUpEn | output | 8 | Per-bit strong pull-up pulse |
| keeperEn | output | 8 | Per-bit keeper pull-up enable |
| weakUpEn | output | 8 | Per-bit very weak pull-up enable |

## Verification
The assertions assume that bitSel always holds a valid bit index while bitEn is high. They also assume that padIn is a clean digital level at each sampling edge. The stimulus drives every input on the falling clock edge, so each value is stable by the rising edge, and it uses only bitSel values from 0 to 7. Pin levels are set directly by the bench. They are never tied to the pad controls, so cases such as a released pin held low from outside, or a high pin under a low latch, can be set up on purpose.

// File: rtl/qbport_pkg.sv
package qbport_pkg;
  localparam int PORT_W = 8;
  localparam int IDX_W  = $clog2(PORT_W);

  typedef struct packed {
    logic             loadByte;
    logic             loadBit;
    logic [IDX_W-1:0] bitIdx;
    logic             bitVal;
    logic             readLatch;
  } strobe_t;
endpackage

// File: rtl/qbport_ctrl.sv
module qbport_ctrl
  import qbport_pkg::*;
(
  input  logic             wrEn,
  input  logic             bitEn,
  input  logic [IDX_W-1:0] bitSel,
  input  logic             bitVal,
  input  logic             rdRmw,
  output strobe_t          strobe
);
  always_comb begin
    strobe.loadByte  = wrEn;
    strobe.loadBit   = bitEn && !wrEn;  // byte write wins over bit modify
    strobe.bitIdx    = bitSel;
    strobe.bitVal    = bitVal;
    strobe.readLatch = rdRmw;
  end
endmodule

// File: rtl/qbport_dp.sv
module qbport_dp
  import qbport_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] rdData,
  output logic [PORT_W-1:0] pullDownEn,
  output logic [PORT_W-1:0] strongUpEn,
  output logic [PORT_W-1:0] keeperEn,
  output logic [PORT_W-1:0] weakUpEn
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  logic [PORT_W-1:0] latchQ;
  logic [PORT_W-1:0] latchNext;
  logic [PORT_W-1:0] riseMask;
  logic [PORT_W-1:0] fallMask;
  logic [PORT_W-1:0] pinSync;
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];

  // Next latch value: whole byte or a read-modify-write of one bit
  always_comb begin
    latchNext = latchQ;
    if (strobe.loadByte)
      latchNext = wrData;
    else if (strobe.loadBit)
      latchNext[strobe.bitIdx] = strobe.bitVal;
  end

  assign riseMask = latchNext & ~latchQ;
  assign fallMask = latchQ & ~latchNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= '1;
    else       latchQ <= latchNext;
  end

  // Pin synchroniser chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '1;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign pinSync = syncQ[SYNC_STAGES-1];

  // Per-bit strong pull-up pulse timers
  generate
    for (genvar b = 0; b < PORT_W; b++) begin : gPulse
      logic [CNT_W-1:0] cntQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                cntQ <= '0;
        else if (riseMask[b])     cntQ <= CNT_LOAD;
        else if (fallMask[b])     cntQ <= '0;
        else if (cntQ != '0)      cntQ <= cntQ - 1'b1;
      end
      assign strongUpEn[b] = (cntQ != '0);
    end
  endgenerate

  assign pullDownEn = ~latchQ;
  assign weakUpEn   = latchQ;
  assign keeperEn   = pinSync & latchQ;
  assign rdData     = strobe.readLatch ? latchQ : pinSync;
endmodule

// File: rtl/qbport_top.sv
module qbport_top
  import qbport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [PORT_W-1:0] wrData,
  input  logic              bitEn,
  input  logic [IDX_W-1:0]  bitSel,
  input  logic              bitVal,
  input  logic              rdRmw,
  output logic [PORT_W-1:0] rdData,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] pullDownEn,
  output logic [PORT_W-1:0] strongUpEn,
  output logic [PORT_W-1:0] keeperEn,
  output logic [PORT_W-1:0] weakUpEn
);
  strobe_t strobe;

  qbport_ctrl uCtrl (
    .wrEn   (wrEn),
    .bitEn  (bitEn),
    .bitSel (bitSel),
    .bitVal (bitVal),
    .rdRmw  (rdRmw),
    .strobe (strobe)
  );

  qbport_dp #(.SYNC_STAGES(2), .PULSE_CYCLES(2)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .padIn      (padIn),
    .rdData     (rdData),
    .pullDownEn (pullDownEn),
    .strongUpEn (strongUpEn),
    .keeperEn   (keeperEn),
    .weakUpEn   (weakUpEn)
  );
endmodule

// File: rtl/qbport_checker.sv
module qbport_checker
  import qbport_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [PORT_W-1:0] wrData,
  input logic              bitEn,
  input logic [IDX_W-1:0]  bitSel,
  input logic              rdRmw,
  input logic [PORT_W-1:0] rdData,
  input logic [PORT_W-1:0] pullDownEn,
  input logic [PORT_W-1:0] strongUpEn,
  input logic [PORT_W-1:0] keeperEn,
  input logic [PORT_W-1:0] weakUpEn
);
  assert_rmw_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdRmw |-> rdData == weakUpEn);

  assert_byte_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> weakUpEn == $past(wrData));

  assert_bit_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !wrEn) |=>
      (((weakUpEn ^ $past(weakUpEn)) & ~(PORT_W'(1) << $past(bitSel))) == '0));

  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((strongUpEn & ~$past(strongUpEn) & ~$past(pullDownEn)) == '0));

  assert_keeper_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((keeperEn & ~weakUpEn) == '0));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((pullDownEn & (strongUpEn | keeperEn | weakUpEn)) == '0));

  generate
    for (genvar b = 0; b < PORT_W; b++) begin : gBit
      assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rstN)
        $rose(strongUpEn[b]) |=> (strongUpEn[b] || pullDownEn[b]));
      assert_pulse_end_R8: assert property (@(posedge clk) disable iff (!rstN)
        (strongUpEn[b] && $past(strongUpEn[b])) |=> !strongUpEn[b]);
    end
  endgenerate
endmodule

bind qbport_top qbport_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .bitEn      (bitEn),
  .bitSel     (bitSel),
  .rdRmw      (rdRmw),
  .rdData     (rdData),
  .pullDownEn (pullDownEn),
  .strongUpEn (strongUpEn),
  .keeperEn   (keeperEn),
  .weakUpEn   (weakUpEn)
);

// File: tb/qbport_top_test.sv
`timescale 1ns/1ps
module qbport_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       bitEn = 1'b0;
  logic [2:0] bitSel = 3'd0;
  logic       bitVal = 1'b0;
  logic       rdRmw = 1'b0;
  logic [7:0] rdData;
  logic [7:0] padIn = 8'hFF;
  logic [7:0] pullDownEn, strongUpEn, keeperEn, weakUpEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  qbport_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .bitEn(bitEn),
    .bitSel(bitSel), .bitVal(bitVal), .rdRmw(rdRmw), .rdData(rdData),
    .padIn(padIn), .pullDownEn(pullDownEn), .strongUpEn(strongUpEn),
    .keeperEn(keeperEn), .weakUpEn(weakUpEn)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic readPort(input logic rmw, output logic [7:0] val);
    rdRmw = rmw;
    #0.5;
    val = rdData;
    rdRmw = 1'b0;
  endtask

  // drive at negedge, release at the next negedge (one posedge between)
  task automatic writeByte(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeBit(input logic [2:0] idx, input logic v);
    bitEn = 1'b1; bitSel = idx; bitVal = v;
    @(negedge clk);
    bitEn = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] r;
    check("R1", "weakUp", weakUpEn, 8'hFF);
    check("R1", "pullDown", pullDownEn, 8'h00);
    check("R1", "strong", strongUpEn, 8'h00);
    readPort(1'b1, r);
    check("R1", "rmw read", r, 8'hFF);
  endtask

  task automatic testByteAndPulse();
    writeByte(8'h00);
    check("R4", "pullDown after 00", pullDownEn, 8'hFF);
    check("R4", "weakUp after 00", weakUpEn, 8'h00);
    check("R7", "no pulse on 1->0", strongUpEn, 8'h00);
    writeByte(8'hA5);
    check("R7", "pulse cycle 1", strongUpEn, 8'hA5);
    check("R4", "pullDown after A5", pullDownEn, 8'h5A);
    @(negedge clk);
    check("R7", "pulse cycle 2", strongUpEn, 8'hA5);
    @(negedge clk);
    check("R7", "pulse ended", strongUpEn, 8'h00);
  endtask

  task automatic testNoRestart();
    writeByte(8'h00);
    writeByte(8'h0F);
    check("R7", "low nibble pulse", strongUpEn, 8'h0F);
    writeByte(8'hFF);
    check("R8", "mixed pulse", strongUpEn, 8'hFF);
    @(negedge clk);
    check("R8", "low nibble not restarted", strongUpEn, 8'hF0);
    @(negedge clk);
    check("R8", "all ended", strongUpEn, 8'h00);
  endtask

  task automatic testCancel();
    writeByte(8'h00);
    writeByte(8'h01);
    check("R7", "bit0 pulse", strongUpEn, 8'h01);
    writeByte(8'h00);
    check("R8", "pulse cancelled", strongUpEn, 8'h00);
    check("R8", "pulldown back on", pullDownEn, 8'hFF);
    @(negedge clk);
    check("R8", "still no pulse", strongUpEn, 8'h00);
  endtask

  task automatic testHeldLow();
    logic [7:0] r;
    writeByte(8'hFF);
    padIn = 8'hFE;
    @(negedge clk);
    readPort(1'b0, r);
    check("R2", "pin read after 1 edge", r, 8'hFF);
    @(negedge clk);
    readPort(1'b0, r);
    check("R2", "pin read after 2 edges", r, 8'hFE);
    readPort(1'b1, r);
    check("R3", "latch read with pin low", r, 8'hFF);
    check("R9", "keeper off on low pin", keeperEn, 8'hFE);
    padIn = 8'hFF;
    repeat (2) @(negedge clk);
    check("R9", "keeper back on", keeperEn, 8'hFF);
  endtask

  task automatic testBitOps();
    logic [7:0] r;
    writeByte(8'h3C);
    repeat (2) @(negedge clk);
    writeBit(3'd0, 1'b1);
    readPort(1'b1, r);
    check("R5", "set bit0", r, 8'h3D);
    check("R7", "bit op pulse", strongUpEn, 8'h01);
    writeBit(3'd2, 1'b0);
    readPort(1'b1, r);
    check("R5", "clear bit2", r, 8'h39);
    writeBit(3'd7, 1'b1);
    readPort(1'b1, r);
    check("R5", "set bit7", r, 8'hB9);
  endtask

  task automatic testPriority();
    logic [7:0] r;
    wrEn = 1'b1; wrData = 8'h00;
    bitEn = 1'b1; bitSel = 3'd3; bitVal = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; bitEn = 1'b0;
    readPort(1'b1, r);
    check("R6", "byte write wins", r, 8'h00);
  endtask

  task automatic testExclusion();
    padIn = 8'hFF;
    writeByte(8'h00);
    repeat (2) @(negedge clk);
    check("R10", "keeper off under pulldown", keeperEn, 8'h00);
    check("R10", "no pull-ups under pulldown",
          pullDownEn & (strongUpEn | keeperEn | weakUpEn), 8'h00);
    writeByte(8'h55);
    check("R10", "exclusive during pulse",
          pullDownEn & (strongUpEn | keeperEn | weakUpEn), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testByteAndPulse();
    testNoRestart();
    testCancel();
    testHeldLow();
    testBitOps();
    testPriority();
    testExclusion();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule